// File: doc/BRIEF.md
# Two-Line Two-Edge PDM Microphone Channel Router

This block sits between a set of PDM microphones and the decimation filters of an audio capture path. It generates the PDM bit clock itself from the system clock, so it is always the clock master on the microphone side. Two data lines come back from the microphones. Each line is shared by two microphones: one drives its bit for the half period that ends on the rising clock edge, and the other drives its bit for the half period that ends on the falling edge. That gives four microphone slots.

Each logical output channel picks one of those four slots through two configuration bits. It also has its own enable bit. Once per PDM period, each enabled channel hands one bit to its decimator together with a one-cycle valid strobe. Several channels may point at the same slot, and each of them then carries a copy of that stream. Microphones need tens of milliseconds after power-up, or longer after a wake-up, before their output is meaningful. The system holds a channel disabled, or discards its early samples, until that time has passed. The block neither measures nor enforces that delay.

Top module: `pdm_slot_router`

## Requirements
- R1: While reset is held, `pdm_clk` is low and `ch_valid` is all zero.
- R2: `pdm_clk` is a square wave. Each level lasts exactly HALF_DIV system clock cycles, starting with a low phase of HALF_DIV cycles out of reset.
- R3: A rising-edge slot bit is the line value present at the system clock edge where `pdm_clk` goes high. Slot index 2·line + 0.
- R4: A falling-edge slot bit is the line value present at the system clock edge where `pdm_clk` goes low. Slot index 2·line + 1.
- R5: `cfg_word` bit (2·ch + 16) selects the data line of channel ch: 0 selects `pdm_din[0]` and 1 selects `pdm_din[1]`.
- R6: `cfg_word` bit (2·ch) selects the edge of channel ch: 0 selects the rising-edge slot and 1 selects the falling-edge slot.
- R7: `chan_en` bit ch enables channel ch. A disabled channel never raises its `ch_valid` bit.
- R8: Each enabled channel raises `ch_valid` for exactly one system cycle per PDM period. That cycle is the first one in which `pdm_clk` reads low after a high phase. `ch_bit` is valid in the same cycle.
- R9: Enable is sampled when `pdm_clk` goes high. A channel enabled after that edge delivers nothing for the current period and starts with the next full period.
- R10: Two enabled channels that select the same slot deliver identical bits in the same cycle, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Per-channel edge select at bit 2·ch, line select at bit 2·ch+16 |
| chan_en | input | NUM_CH | Per-channel enable, bit ch for channel ch |
| pdm_din | input | 2 | Shared microphone data lines |
| pdm_clk | output | 1 | Generated PDM bit clock |
| ch_bit | output | NUM_CH | Routed PDM bit per channel |
| ch_valid | output | NUM_CH | One-cycle strobe per channel and PDM period |

## Verification
The assertions assume that the microphone lines are only captured inside the block, and that `cfg_word` is a quasi-static setting. The shared-slot property reads the configuration from the cycle before the strobe. To match this, the stimulus changes `cfg_word` and `chan_en` only just after a falling PDM edge, or after a rising edge in the late-enable case. It changes `pdm_din` right after each PDM clock transition, so the value stays stable across the whole half period before the edge that samples it. The scoreboard draws the slot bits at random each period and builds the expected value of every channel from the bit positions stated in the requirements.

// File: rtl/pdm_router_pkg.sv
package pdm_router_pkg;
   localparam int LINES         = 2;
   localparam int EDGES         = 2;
   localparam int SLOTS         = LINES * EDGES;
   localparam int CFG_W         = 32;
   localparam int EDGE_SEL_BASE = 0;
   localparam int LINE_SEL_BASE = 16;
   localparam int MAX_CH        = 4;

   typedef logic [1:0] slot_idx_t;

   // slot index = {line select, edge select}
   function automatic slot_idx_t slot_of(input logic [CFG_W-1:0] cfg, input int ch);
      return {cfg[LINE_SEL_BASE + 2*ch], cfg[EDGE_SEL_BASE + 2*ch]};
   endfunction

   function automatic logic [CFG_W-1:0] cfg_used_mask(input int nch);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int c = 0; c < nch; c++) begin
         m[EDGE_SEL_BASE + 2*c] = 1'b1;
         m[LINE_SEL_BASE + 2*c] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic pdm_clk,
   output logic rise_evt,
   output logic fall_evt
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == CW'(HALF_DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         pdm_clk <= 1'b0;
      end else if (wrap) begin
         cnt     <= '0;
         pdm_clk <= ~pdm_clk;
      end else begin
         cnt     <= cnt + 1'b1;
      end
   end

   // events mark the system edge at which pdm_clk changes level
   assign rise_evt = wrap & ~pdm_clk;
   assign fall_evt = wrap &  pdm_clk;
endmodule

// File: rtl/pdm_line_capture.sv
module pdm_line_capture
   import pdm_router_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_evt,
   input  logic             fall_evt,
   input  logic [LINES-1:0] din,
   output logic [SLOTS-1:0] slot_vec,
   output logic             frame_evt
);
   logic [LINES-1:0] din_s;
   logic [LINES-1:0] rise_hold;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         logic [LINES-1:0] stg;
         always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= din;
         end
         assign din_s = stg;
      end else begin : g_chain
         logic [LINES-1:0] stg [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= din;
         end
         for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
         assign din_s = stg[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        rise_hold <= '0;
      else if (rise_evt) rise_hold <= din_s;
   end

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_slot
         assign slot_vec[2*l]     = rise_hold[l];
         assign slot_vec[2*l + 1] = din_s[l];
      end
   endgenerate

   // both slots of every line are complete at the falling edge
   assign frame_evt = fall_evt;
endmodule

// File: rtl/pdm_chan_select.sv
module pdm_chan_select
   import pdm_router_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_evt,
   input  logic              frame_evt,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic [NUM_CH-1:0] chan_en,
   input  logic [SLOTS-1:0]  slot_vec,
   output logic [NUM_CH-1:0] ch_bit,
   output logic [NUM_CH-1:0] ch_valid
);
   localparam logic [CFG_W-1:0] USED = cfg_used_mask(NUM_CH);

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^(cfg_word & ~USED);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         slot_idx_t sel;
         logic      armed;
         logic      bit_q;
         logic      vld_q;

         assign sel = slot_of(cfg_word, c);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               armed <= 1'b0;
               bit_q <= 1'b0;
               vld_q <= 1'b0;
            end else begin
               if (rise_evt) armed <= chan_en[c];
               vld_q <= frame_evt & armed & chan_en[c];
               if (frame_evt) bit_q <= slot_vec[sel];
            end
         end

         assign ch_bit[c]   = bit_q;
         assign ch_valid[c] = vld_q;
      end
   endgenerate
endmodule

// File: rtl/pdm_slot_router.sv
module pdm_slot_router
   import pdm_router_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_word,
   input  logic [NUM_CH-1:0] chan_en,
   input  logic [1:0]        pdm_din,
   output logic              pdm_clk,
   output logic [NUM_CH-1:0] ch_bit,
   output logic [NUM_CH-1:0] ch_valid
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("pdm_slot_router: NUM_CH must be 1..4");
      end
      if (HALF_DIV < 2) begin : g_bad_div
         $error("pdm_slot_router: HALF_DIV must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pdm_slot_router: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic             rise_evt;
   logic             fall_evt;
   logic             frame_evt;
   logic [SLOTS-1:0] slot_vec;

   pdm_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .pdm_clk  (pdm_clk),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   pdm_line_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_evt  (rise_evt),
      .fall_evt  (fall_evt),
      .din       (pdm_din),
      .slot_vec  (slot_vec),
      .frame_evt (frame_evt)
   );

   pdm_chan_select #(.NUM_CH(NUM_CH)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_evt  (rise_evt),
      .frame_evt (frame_evt),
      .cfg_word  (cfg_word),
      .chan_en   (chan_en),
      .slot_vec  (slot_vec),
      .ch_bit    (ch_bit),
      .ch_valid  (ch_valid)
   );
endmodule

// File: rtl/pdm_slot_router_checker.sv
module pdm_slot_router_checker
   import pdm_router_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int HALF_DIV = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       cfg_word,
   input logic [NUM_CH-1:0] chan_en,
   input logic              pdm_clk,
   input logic [NUM_CH-1:0] ch_bit,
   input logic [NUM_CH-1:0] ch_valid
);
   localparam int HW = $clog2(HALF_DIV + 2);
   localparam logic [CFG_W-1:0] USED = cfg_used_mask(NUM_CH);

   logic          clk_prev;
   logic [HW-1:0] hold;
   logic [31:0]   cfg_prev;
   logic          unused_cfg_prev;

   assign unused_cfg_prev = ^(cfg_prev & ~USED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         hold     <= '0;
         cfg_prev <= '0;
      end else begin
         clk_prev <= pdm_clk;
         hold     <= (pdm_clk != clk_prev) ? HW'(1) : hold + 1'b1;
         cfg_prev <= cfg_word;
      end
   end

   p_clk_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pdm_clk != clk_prev) |-> (hold == HW'(HALF_DIV)));

   p_valid_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_valid) |-> (!pdm_clk && clk_prev));

   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_valid) |=> (ch_valid == '0));

   p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid & ~$past(chan_en)) == '0);

   generate
      for (genvar a = 0; a < NUM_CH; a++) begin : g_a
         for (genvar b = a + 1; b < NUM_CH; b++) begin : g_b
            p_shared_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
               (ch_valid[a] && ch_valid[b] && slot_of(cfg_prev, a) == slot_of(cfg_prev, b))
               |-> (ch_bit[a] == ch_bit[b]));
         end
      end
   endgenerate
endmodule

bind pdm_slot_router pdm_slot_router_checker #(
   .NUM_CH   (NUM_CH),
   .HALF_DIV (HALF_DIV)
) u_chk (.*);

// File: tb/pdm_slot_router_test.sv
module pdm_slot_router_test;
   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_word = '0;
   logic [3:0]  chan_en = '0;
   logic [1:0]  pdm_din = '0;
   logic        pdm_clk;
   logic [3:0]  ch_bit;
   logic [3:0]  ch_valid;

   always #10 clk = ~clk;

   pdm_slot_router #(.NUM_CH(4), .HALF_DIV(HALF), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .chan_en(chan_en),
      .pdm_din(pdm_din), .pdm_clk(pdm_clk), .ch_bit(ch_bit), .ch_valid(ch_valid)
   );

   typedef struct { logic b; string tag; } exp_t;
   exp_t sb_q[4][$];

   int errors = 0;
   int checks = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // monitor: compares strobed bits against the scoreboard
   logic       prev_pdm = 1'b0;
   logic [3:0] prev_valid = '0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (|ch_valid) begin
            check(prev_pdm && !pdm_clk, "R8", "strobe not at first low cycle",
                  {prev_pdm, pdm_clk}, 2);
            check(prev_valid == 0, "R8", "strobe longer than one cycle", prev_valid, 0);
         end
         for (int c = 0; c < 4; c++) begin
            if (ch_valid[c]) begin
               if (sb_q[c].size() == 0) begin
                  check(1'b0, "R7", $sformatf("unexpected strobe on ch%0d", c), 1, 0);
               end else begin
                  exp_t e;
                  e = sb_q[c].pop_front();
                  check(ch_bit[c] == e.b, e.tag, $sformatf("ch%0d bit", c), ch_bit[c], e.b);
               end
            end
         end
         prev_pdm   = pdm_clk;
         prev_valid = ch_valid;
      end
   end

   task automatic wait_level(input logic v);
      while (pdm_clk === v) @(negedge clk);
      while (pdm_clk !== v) @(negedge clk);
   endtask

   // driver: one PDM period, entered just after a falling PDM edge
   task automatic run_period(input logic [3:0] en, input logic [31:0] cfg,
                             input logic [3:0] late, input string tag);
      logic [1:0] rb;
      logic [1:0] fb;
      logic [3:0] slots;
      exp_t       e;
      chan_en  = en;
      cfg_word = cfg;
      rb = 2'($urandom_range(0, 3));
      fb = 2'($urandom_range(0, 3));
      slots = {fb[1], rb[1], fb[0], rb[0]};
      pdm_din = rb;
      for (int c = 0; c < 4; c++) begin
         if (en[c]) begin
            e.b   = slots[{cfg[2*c + 16], cfg[2*c]}];
            e.tag = tag;
            sb_q[c].push_back(e);
         end
      end
      wait_level(1'b1);
      pdm_din = fb;
      chan_en = en | late;
      wait_level(1'b0);
   endtask

   initial begin
      int n;
      repeat (5) @(negedge clk);
      check(pdm_clk == 1'b0, "R1", "pdm_clk in reset", pdm_clk, 0);
      check(ch_valid == 4'h0, "R1", "ch_valid in reset", ch_valid, 0);
      rst_n = 1'b1;

      // R2: high phase length
      wait_level(1'b1);
      n = 0;
      while (pdm_clk == 1'b1) begin
         n++;
         @(negedge clk);
      end
      check(n == HALF, "R2", "high phase cycles", n, HALF);
      // low phase length
      n = 0;
      while (pdm_clk == 1'b0) begin
         n++;
         @(negedge clk);
      end
      check(n == HALF, "R2", "low phase cycles", n, HALF);
      wait_level(1'b0);

      // identity map: ch0 L0 rise, ch1 L0 fall, ch2 L1 rise, ch3 L1 fall
      for (int i = 0; i < 10; i++)
         run_period(4'hF, 32'h0050_0044, 4'h0, "R3 R4 R5 R6");
      // reversed map
      for (int i = 0; i < 10; i++)
         run_period(4'hF, 32'h0005_0011, 4'h0, "R5 R6");
      // all channels on line 1 falling slot
      for (int i = 0; i < 6; i++)
         run_period(4'hF, 32'h0055_0055, 4'h0, "R10");
      // partial enable, unused config bits toggled
      for (int i = 0; i < 6; i++)
         run_period(4'h5, 32'hAA00_AA44 | 32'h0050_0044, 4'h0, "R7");
      // late enable of ch1: nothing this period, data from the next
      run_period(4'h1, 32'h0050_0044, 4'h2, "R9");
      for (int i = 0; i < 4; i++)
         run_period(4'h3, 32'h0050_0044, 4'h0, "R9");
      // all disabled
      for (int i = 0; i < 3; i++)
         run_period(4'h0, 32'h0050_0044, 4'h0, "R7");

      repeat (4 * HALF) @(negedge clk);
      for (int c = 0; c < 4; c++)
         check(sb_q[c].size() == 0, "R8", $sformatf("missing strobes ch%0d", c),
               sb_q[c].size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL R8 watchdog: actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule